// File: doc/BRIEF.md
# Clock Stop and Power-Down Controller

This block sits between a set of free-running clocks and the output pins that carry them. It serves four clock groups: a processor clock, a memory (SDRAM) clock, a PCI/AGP bus clock and an early PCI clock. Each group has its own gate, its own enable synchronizer and its own enable register. A gated output is only ever parked low, and its enable changes only while the source clock is low. Every high pulse that leaves the block is therefore full width.

Two active-low stop requests control the groups, and a mode input selects whether those requests are obeyed. The two requests are coupled. The processor stop parks only the processor clock. Adding the bus stop parks the bus clocks and the memory clock as well. The bus stop on its own does nothing.

An asynchronous active-low power-down input overrides all of this in every mode. It parks every output at the end of its current high phase and raises a power-down flag. When power-down is released, or after reset, a wake-up counter in the reference domain keeps all outputs low for a programmable number of cycles. This interval stands in for oscillator settling. The processor clock also has a restart hold: after its stop is released it waits a minimum number of its own cycles before it runs again.

Top module: `clkstop_ctrl`

## Requirements
- R1: With mode at 0 and the bus stop inactive (high), driving the processor stop low parks the processor output low. The memory, bus and early bus outputs keep running.
- R2: With mode at 0, driving the processor stop and the bus stop low together also parks the memory output low.
- R3: The bus stop parks the bus output and the early bus output only while the processor stop is also low. With the processor stop high, a low bus stop leaves all four outputs running.
- R4: After the processor stop is released, the processor output does not run again until at least CPU_HOLD_CYC (default 3) rising edges of the processor clock have passed.
- R5: With mode at 1, both stop inputs are ignored and all four outputs keep running.
- R6: A low power-down input parks every output low in either mode, and the power-down flag reads 1 while it is low.
- R7: After reset, and after power-down is released, every output stays low and the flag stays 1 for at least WAKE_CYC reference cycles. The outputs then follow the stop requests.
- R8: An enable changes only while its source clock is low, so no output high pulse is shorter than the source high phase. This holds even when power-down arrives during a high phase.
- R9: In the run status vector, bit 0 is the processor group, bit 1 memory, bit 2 bus and bit 3 early bus. A bit reads 1 while that group's output is enabled and 0 while it is parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock for request decode and wake-up counting |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Free-running processor clock source |
| sdram_clk_i | input | 1 | Free-running memory clock source |
| pci_clk_i | input | 1 | Free-running bus clock source |
| epci_clk_i | input | 1 | Free-running early bus clock source |
| mode_i | input | 1 | 0 obeys the stop inputs, 1 ignores them |
| cpu_stop_n_i | input | 1 | Active-low processor stop request |
| pci_stop_n_i | input | 1 | Active-low bus stop request |
| pwrdn_n_i | input | 1 | Asynchronous active-low power-down |
| cpu_clk_o | output | 1 | Gated processor clock |
| sdram_clk_o | output | 1 | Gated memory clock |
| pci_clk_o | output | 1 | Gated bus clock |
| epci_clk_o | output | 1 | Gated early bus clock |
| run_status_o | output | 4 | Per-group running flags, encoded as in R9 |
| pwrdn_flag_o | output | 1 | 1 during power-down and the wake-up hold |

## Verification
The processor restart hold and an asynchronous power-down can land in the same cycle. At that moment the processor gate is counting toward release while the power-down forces its synchronizer back to the stopped state. The bench provokes this by releasing the processor stop and pulling power-down low together, one nanosecond after a rising edge, so that the outputs are in their high phase. It expects all status bits at 0, the flag at 1 and no edges on any output. A pulse-width monitor must also record no shortened high phase on any output over the whole run.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  localparam int NUM_GRP   = 4;
  localparam int GRP_CPU   = 0;
  localparam int GRP_SDRAM = 1;
  localparam int GRP_PCI   = 2;
  localparam int GRP_EPCI  = 3;
  typedef logic [NUM_GRP-1:0] grp_vec_t;
endpackage

// File: rtl/clkstop_wake.sv
module clkstop_wake #(
  parameter int WAKE_CYC    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pwrdn_n_i,
  output logic pd_active_o
);
  localparam int CNTW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);

  logic                   wake_rst_n;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CNTW-1:0]        cnt_q, cnt_d;
  logic                   act_q, act_d;

  assign wake_rst_n = rst_n_i & pwrdn_n_i;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
    cnt_d  = cnt_q;
    act_d  = act_q;
    if (sync_q[SYNC_STAGES-1] && act_q) begin
      if (cnt_q == CNTW'(WAKE_CYC - 1)) begin
        act_d = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge wake_rst_n) begin
    if (!wake_rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b1;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
    end
  end

  assign pd_active_o = act_q;

  // checker: cycles elapsed since the release was synchronized
  logic [CNTW:0] chk_q;
  always_ff @(posedge clk_i or negedge wake_rst_n) begin
    if (!wake_rst_n) begin
      chk_q <= '0;
    end else if (sync_q[SYNC_STAGES-1] && (chk_q != (CNTW+1)'(WAKE_CYC))) begin
      chk_q <= chk_q + 1'b1;
    end
  end

  AST_WAKE_MIN_HOLD: assert property (@(posedge clk_i) disable iff (!wake_rst_n)
    $fell(act_q) |-> (chk_q >= (CNTW+1)'(WAKE_CYC))) else $error("wake hold too short"); // R7
endmodule

// File: rtl/clkstop_decode.sv
module clkstop_decode
  import clkstop_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_n_i,
  input  logic     mode_i,
  input  logic     cpu_stop_n_i,
  input  logic     pci_stop_n_i,
  input  logic     pd_active_i,
  output grp_vec_t stop_req_o
);
  grp_vec_t stop_q, stop_d;
  logic     cpu_halt, bus_halt;

  always_comb begin
    cpu_halt = !mode_i && !cpu_stop_n_i;
    bus_halt = cpu_halt && !pci_stop_n_i;
    stop_d            = '0;
    stop_d[GRP_CPU]   = cpu_halt;
    stop_d[GRP_SDRAM] = bus_halt;
    stop_d[GRP_PCI]   = bus_halt;
    stop_d[GRP_EPCI]  = bus_halt;
    if (pd_active_i) stop_d = '1;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stop_q <= '1;
    else          stop_q <= stop_d;
  end

  assign stop_req_o = stop_q;

  AST_MODE_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mode_i && !pd_active_i) |=> (stop_q == '0)) else $error("mode 1 stop leaked"); // R5
  AST_SDRAM_COUPLED: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    stop_q[GRP_SDRAM] |-> (stop_q[GRP_CPU] && stop_q[GRP_PCI])) else $error("memory stop uncoupled"); // R2
  AST_BUS_NEEDS_CPU: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (stop_q[GRP_PCI] || stop_q[GRP_EPCI]) |-> stop_q[GRP_CPU]) else $error("bus stop alone"); // R3
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int HOLD_CYC    = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic gclk_i,
  input  logic rst_n_i,
  input  logic force_n_i,
  input  logic stop_req_i,
  output logic gclk_o,
  output logic running_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   stop_s;
  logic                   run_req;
  logic                   en_q;

  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], stop_req_i};

  always_ff @(posedge gclk_i or negedge force_n_i) begin
    if (!force_n_i) sync_q <= '1;
    else            sync_q <= sync_d;
  end

  assign stop_s = sync_q[SYNC_STAGES-1];

  generate
    if (HOLD_CYC == 0) begin : g_nohold
      assign run_req = ~stop_s;
    end else begin : g_hold
      localparam int HW = $clog2(HOLD_CYC + 1);
      logic [HW-1:0] cnt_q, cnt_d;
      logic          run_q, run_d;
      logic [HW:0]   chk_q;

      always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (stop_s) begin
          cnt_d = '0;
          run_d = 1'b0;
        end else if (cnt_q == HW'(HOLD_CYC)) begin
          run_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge gclk_i or negedge force_n_i) begin
        if (!force_n_i) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_d;
          run_q <= run_d;
        end
      end

      assign run_req = run_q;

      // checker: source edges seen since the synchronized release
      always_ff @(posedge gclk_i or negedge force_n_i) begin
        if (!force_n_i)                           chk_q <= '0;
        else if (stop_s)                          chk_q <= '0;
        else if (chk_q != (HW+1)'(HOLD_CYC + 1))  chk_q <= chk_q + 1'b1;
      end

      AST_RESTART_HOLD: assert property (@(posedge gclk_i) disable iff (!force_n_i)
        $rose(run_q) |-> (chk_q >= (HW+1)'(HOLD_CYC))) else $error("restart too early"); // R4
    end
  endgenerate

  // enable moves only on the falling edge, while the source is low
  always_ff @(negedge gclk_i or negedge rst_n_i) begin
    if (!rst_n_i) en_q <= 1'b0;
    else          en_q <= run_req;
  end

  assign gclk_o    = gclk_i & en_q;
  assign running_o = en_q;

  always @(en_q) begin
    if (rst_n_i) begin
      AST_EN_CHANGE_LOW: assert (!gclk_i) else $error("enable moved in high phase"); // R8
    end
  end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int WAKE_CYC     = 16,
  parameter int CPU_HOLD_CYC = 3,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                clk_ref_i,
  input  logic                rst_n_i,
  input  logic                cpu_clk_i,
  input  logic                sdram_clk_i,
  input  logic                pci_clk_i,
  input  logic                epci_clk_i,
  input  logic                mode_i,
  input  logic                cpu_stop_n_i,
  input  logic                pci_stop_n_i,
  input  logic                pwrdn_n_i,
  output logic                cpu_clk_o,
  output logic                sdram_clk_o,
  output logic                pci_clk_o,
  output logic                epci_clk_o,
  output logic [NUM_GRP-1:0]  run_status_o,
  output logic                pwrdn_flag_o
);
  grp_vec_t src_clk, gated_clk, stop_req, running;
  logic     pd_active;
  logic     force_n;

  assign force_n = rst_n_i & pwrdn_n_i;

  assign src_clk[GRP_CPU]   = cpu_clk_i;
  assign src_clk[GRP_SDRAM] = sdram_clk_i;
  assign src_clk[GRP_PCI]   = pci_clk_i;
  assign src_clk[GRP_EPCI]  = epci_clk_i;

  clkstop_wake #(
    .WAKE_CYC   (WAKE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) wake_i (
    .clk_i      (clk_ref_i),
    .rst_n_i    (rst_n_i),
    .pwrdn_n_i  (pwrdn_n_i),
    .pd_active_o(pd_active)
  );

  clkstop_decode decode_i (
    .clk_i       (clk_ref_i),
    .rst_n_i     (rst_n_i),
    .mode_i      (mode_i),
    .cpu_stop_n_i(cpu_stop_n_i),
    .pci_stop_n_i(pci_stop_n_i),
    .pd_active_i (pd_active),
    .stop_req_o  (stop_req)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int HOLD = (g == GRP_CPU) ? CPU_HOLD_CYC : 0;
    clkstop_gate #(
      .HOLD_CYC   (HOLD),
      .SYNC_STAGES(SYNC_STAGES)
    ) gate_i (
      .gclk_i    (src_clk[g]),
      .rst_n_i   (rst_n_i),
      .force_n_i (force_n),
      .stop_req_i(stop_req[g]),
      .gclk_o    (gated_clk[g]),
      .running_o (running[g])
    );
  end

  assign cpu_clk_o    = gated_clk[GRP_CPU];
  assign sdram_clk_o  = gated_clk[GRP_SDRAM];
  assign pci_clk_o    = gated_clk[GRP_PCI];
  assign epci_clk_o   = gated_clk[GRP_EPCI];
  assign run_status_o = running;
  assign pwrdn_flag_o = pd_active;

  AST_PD_FLAG: assert property (@(posedge clk_ref_i) disable iff (!rst_n_i)
    !pwrdn_n_i |-> pwrdn_flag_o) else $error("flag low in power-down"); // R6
endmodule

// File: tb/clkstop_ctrl_tb.sv
module clkstop_ctrl_tb_top;
  localparam int WAKE = 16;

  logic clk = 1'b0;
  logic bus_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, cs_n = 1'b1, ps_n = 1'b1, pd_n = 1'b1;
  logic cpu_o, sdram_o, pci_o, epci_o, flag;
  logic [3:0] status;
  logic [3:0] outs;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) bus_clk <= ~bus_clk;

  clkstop_ctrl #(.WAKE_CYC(WAKE), .CPU_HOLD_CYC(3), .SYNC_STAGES(2)) dut_i (
    .clk_ref_i(clk), .rst_n_i(rst_n),
    .cpu_clk_i(clk), .sdram_clk_i(clk), .pci_clk_i(bus_clk), .epci_clk_i(bus_clk),
    .mode_i(mode), .cpu_stop_n_i(cs_n), .pci_stop_n_i(ps_n), .pwrdn_n_i(pd_n),
    .cpu_clk_o(cpu_o), .sdram_clk_o(sdram_o), .pci_clk_o(pci_o), .epci_clk_o(epci_o),
    .run_status_o(status), .pwrdn_flag_o(flag)
  );

  assign outs = {epci_o, pci_o, sdram_o, cpu_o};

  int edge_cnt [4];
  int short_cnt = 0;

  for (genvar g = 0; g < 4; g++) begin : g_mon
    realtime t_r = 0;
    bit seen = 1'b0;
    always @(posedge outs[g]) begin
      edge_cnt[g] = edge_cnt[g] + 1;
      t_r = $realtime;
      seen = 1'b1;
    end
    always @(negedge outs[g]) begin
      if (seen && ($realtime - t_r) < (((g < 2) ? 2.0 : 4.0) - 0.01))
        short_cnt = short_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [3:0] st;
    logic       pd;
    string      tag;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;

  // monitor: pops an expected item, then watches the outputs for a window
  initial begin
    forever begin
      item_t it;
      int snap [4];
      @(chk_ev);
      it = sb_q.pop_front();
      @(negedge clk);
      check(status == it.st, {it.tag, " status"}, status, it.st);
      check(flag == it.pd, {it.tag, " flag"}, flag, it.pd);
      for (int g = 0; g < 4; g++) snap[g] = edge_cnt[g];
      repeat (16) @(negedge clk);
      for (int g = 0; g < 4; g++) begin
        bit moved;
        moved = (edge_cnt[g] != snap[g]);
        if (it.st[g]) check(moved, {it.tag, " edges"}, moved, 1);
        else          check(!moved && !outs[g], {it.tag, " parked"}, {moved, outs[g]}, 0);
      end
    end
  end

  task automatic expect_state(input logic [3:0] st, input logic pd, input string tag);
    item_t it;
    it.st = st; it.pd = pd; it.tag = tag;
    sb_q.push_back(it);
    -> chk_ev;
    repeat (20) @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    for (int g = 0; g < 4; g++) edge_cnt[g] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 / R7: reset state, every group parked, flag up
    check(status == 4'h0, "R9 reset status", status, 0);
    check(flag == 1'b1, "R7 reset flag", flag, 1);
    settle(WAKE + 30);
    expect_state(4'hF, 1'b0, "R7 run after wake");

    // R1: processor stop only
    cs_n = 1'b0;
    settle(20);
    expect_state(4'hE, 1'b0, "R1 cpu parked");

    // R3: bus stop alone has no effect
    cs_n = 1'b1;
    settle(20);
    ps_n = 1'b0;
    settle(20);
    expect_state(4'hF, 1'b0, "R3 bus stop alone");

    // R2 / R3: both stops park all four
    cs_n = 1'b0;
    settle(20);
    expect_state(4'h0, 1'b0, "R2 both stopped");

    // R4: restart latency counted in processor clock edges
    ps_n = 1'b1;
    settle(20);
    expect_state(4'hE, 1'b0, "R3 bus resumes");
    @(negedge clk);
    cs_n = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!status[0] && n < 40);
    check(n >= 3 && n <= 12, "R4 restart latency", n, 3);

    // R5: mode 1 ignores both stops
    mode = 1'b1;
    cs_n = 1'b0;
    ps_n = 1'b0;
    settle(20);
    expect_state(4'hF, 1'b0, "R5 mode ignores");

    // R6 / R8: power-down in mode 1 during a high phase
    @(posedge clk);
    #1 pd_n = 1'b0;
    settle(10);
    expect_state(4'h0, 1'b1, "R6 pd in mode1");

    // R7: hold during wake, then resume
    cs_n = 1'b1;
    ps_n = 1'b1;
    mode = 1'b0;
    pd_n = 1'b1;
    settle(8);
    check(status == 4'h0, "R7 wake hold status", status, 0);
    check(flag == 1'b1, "R7 wake hold flag", flag, 1);
    settle(WAKE + 30);
    expect_state(4'hF, 1'b0, "R7 resume");

    // R4 + R6 collision: release processor stop and power down together
    cs_n = 1'b0;
    settle(20);
    expect_state(4'hE, 1'b0, "R1 cpu parked again");
    @(posedge clk);
    #1;
    cs_n = 1'b1;
    pd_n = 1'b0;
    settle(10);
    expect_state(4'h0, 1'b1, "R6 collision");
    pd_n = 1'b1;
    settle(WAKE + 30);
    expect_state(4'hF, 1'b0, "R7 after collision");

    // R8: no shortened high pulse anywhere
    check(short_cnt == 0, "R8 pulse width", short_cnt, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule